// File: doc/BRIEF.md
# Byte-Step I2C Master Controller

This block is a single-master I2C engine that software steps one bus action at a time. A small register port holds a transmit/receive data byte, a control byte, a shared status/divider location, a stored own-address byte and a soft-reset strobe. Software requests an action by writing the control byte with the flag bit clear. The action can be a START, a STOP, or the transfer of the next byte. The engine then runs the bus lines through open-drain style outputs. It raises a flag when the step is complete and publishes an 8-bit code that says what happened.

The engine state machine has five states. `E_IDLE` is the bus-free state. `E_START` produces a START or a repeated START. `E_BIT` shifts the eight bits of a byte and the acknowledge slot. `E_HOLD` keeps SCL low while software reacts to the flag. `E_STOP` produces a STOP. These are the transitions:
- `E_IDLE` to `E_START` on a launch with the start bit set.
- `E_START` to `E_HOLD` after four quarter-bit ticks.
- `E_HOLD` to `E_START`, to `E_STOP` or to `E_BIT` on a launch. The start bit has priority over the stop bit, and the stop bit has priority over a byte.
- `E_BIT` to `E_HOLD` after the acknowledge slot.
- `E_STOP` to `E_IDLE` after four ticks.

A stop request that arrives while the engine is in `E_IDLE` only clears the stop bit. Every bit is split into four quarter periods. The tick engine waits before the sampling quarter while SCL is still held low by a slave.

Register offsets on `reg_addr`:
- 0: data byte.
- 1: control byte.
- 2: status on read, clock divider on write.
- 3: stored own address.
- 7: soft reset.

Top module: `i2cm_byte_ctrl`

## Requirements
- R1: After reset the status reads 0xF8, the control byte reads 0x00, the own-address byte reads 0x00, `irq` is low, and both lines are released.
- R2: The control byte fields are: bit 7 interrupt enable, bit 6 engine enable, bit 5 start request, bit 4 stop request, bit 3 flag, bit 2 acknowledge select. Bits 1 and 0 read as zero.
- R3: A start request from the idle bus ends with the flag set and status 0x08. A start request while the bus is still owned ends with status 0x10.
- R4: The first byte after a START is the address byte, and its bit 0 gives the direction (1 = read). The step ends with status 0x18 (write, acknowledged), 0x20 (write, not acknowledged), 0x40 (read, acknowledged) or 0x48 (read, not acknowledged).
- R5: A data byte taken from the data register is sent most significant bit first. The step ends with status 0x28 when the slave acknowledges and 0x30 when it does not.
- R6: In a receive step the acknowledge-select bit of the launching write decides what the master returns: 1 drives an acknowledge (status 0x50) and 0 leaves a not-acknowledge (status 0x58). The received byte is in the data register when the flag rises.
- R7: A stop request does not set the flag. When it completes, the status returns to 0xF8 and SCL and SDA are both released high.
- R8: A control write with bit 3 clear clears the flag and launches the next step. A control write with bit 3 set leaves the flag set, leaves SCL held low and starts nothing.
- R9: `irq` is high exactly while the flag and the interrupt-enable bit are both set.
- R10: While the enable bit of the written control byte is clear, no step is launched: the status stays 0xF8 and the lines stay released.
- R11: Any write to offset 7 returns every register to its reset value. The divider returns to parameter `BAUD_RST` and the own address returns to 0.
- R12: Offset 2 reads the status, and a write to offset 2 sets the divider. One quarter bit lasts (m+1)<<n clock cycles, where m is the divider's bits 7:4 and n is its bits 3:0.
- R13: During a byte step SDA changes only while SCL is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the controller with `BAUD_RST` = 8'h12, which gives a quarter bit of eight cycles. It then programs divider 0 so that the table of transfers runs with one-cycle quarters and a whole byte fits in a few dozen cycles. Because the reset divider and the programmed divider differ, the delay of a START measured before and after a soft reset shows whether the divider was returned to its reset value.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        E_IDLE,
        E_START,
        E_BIT,
        E_HOLD,
        E_STOP
    } eng_state_t;

    // control byte field positions
    localparam int CB_ACK   = 2;
    localparam int CB_FLAG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IEN   = 7;

    // register offsets
    localparam logic [2:0] RO_DATA  = 3'd0;
    localparam logic [2:0] RO_CTRL  = 3'd1;
    localparam logic [2:0] RO_STAT  = 3'd2;
    localparam logic [2:0] RO_OWN   = 3'd3;
    localparam logic [2:0] RO_SRST  = 3'd7;

    // step result codes
    localparam logic [7:0] SC_START    = 8'h08;
    localparam logic [7:0] SC_RSTART   = 8'h10;
    localparam logic [7:0] SC_AW_ACK   = 8'h18;
    localparam logic [7:0] SC_AW_NAK   = 8'h20;
    localparam logic [7:0] SC_DW_ACK   = 8'h28;
    localparam logic [7:0] SC_DW_NAK   = 8'h30;
    localparam logic [7:0] SC_AR_ACK   = 8'h40;
    localparam logic [7:0] SC_AR_NAK   = 8'h48;
    localparam logic [7:0] SC_DR_ACK   = 8'h50;
    localparam logic [7:0] SC_DR_NAK   = 8'h58;
    localparam logic [7:0] SC_IDLE     = 8'hF8;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int M_W = 4,
    parameter int N_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [M_W+N_W-1:0]   divider,
    output logic                 tick
);
    localparam int CNT_W = M_W + 1 + (1 << N_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;

    always_comb begin
        period = (CNT_W'(divider[M_W+N_W-1:N_W]) + CNT_W'(1)) << divider[N_W-1:0];
    end

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == '0) begin
            cnt_q <= period - CNT_W'(1);
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              launch,
    input  logic              req_start,
    input  logic              req_stop,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low,
    output logic              sda_low,
    output logic              step_done,
    output logic              stop_done,
    output logic              data_load,
    output logic [7:0]        status,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              run,
    output logic              idle,
    output logic              in_bit
);
    localparam int BN_W = $clog2(BYTE_W + 1);
    localparam logic [BN_W-1:0] ACK_SLOT = BN_W'(BYTE_W);

    eng_state_t state_q, state_d;
    logic [1:0]        qtr_q;
    logic [BN_W-1:0]   bitn_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              cur_rx_q, ack_drv_q, ack_seen_q;
    logic              addr_phase_q, rd_dir_q, owned_q;
    logic              adv, last_q;
    logic              byte_go;

    // stretch: hold the sampling quarter while SCL is still low
    assign adv     = tick && !(qtr_q == 2'd2 && !scl_i);
    assign last_q  = adv && (qtr_q == 2'd3);
    assign byte_go = launch && !req_start && !req_stop;
    assign run     = (state_q == E_START) || (state_q == E_BIT) || (state_q == E_STOP);
    assign idle    = (state_q == E_IDLE);
    assign in_bit  = (state_q == E_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_IDLE:  if (launch && req_start) state_d = E_START;
            E_START: if (last_q) state_d = E_HOLD;
            E_BIT:   if (last_q && bitn_q == ACK_SLOT) state_d = E_HOLD;
            E_HOLD: begin
                if (launch) begin
                    if (req_start)     state_d = E_START;
                    else if (req_stop) state_d = E_STOP;
                    else               state_d = E_BIT;
                end
            end
            E_STOP:  if (last_q) state_d = E_IDLE;
            default: state_d = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= E_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qtr_q        <= '0;
            bitn_q       <= '0;
            shreg_q      <= '0;
            cur_rx_q     <= 1'b0;
            ack_drv_q    <= 1'b0;
            ack_seen_q   <= 1'b0;
            addr_phase_q <= 1'b0;
            rd_dir_q     <= 1'b0;
            owned_q      <= 1'b0;
            scl_low      <= 1'b0;
            sda_low      <= 1'b0;
            step_done    <= 1'b0;
            stop_done    <= 1'b0;
            data_load    <= 1'b0;
            status       <= SC_IDLE;
            rx_byte      <= '0;
        end else begin
            step_done <= 1'b0;
            stop_done <= 1'b0;
            data_load <= 1'b0;
            unique case (state_q)
                E_IDLE: begin
                    qtr_q <= '0;
                    if (launch && req_stop && !req_start) stop_done <= 1'b1;
                end
                E_HOLD: begin
                    qtr_q <= '0;
                    if (byte_go) begin
                        bitn_q    <= '0;
                        shreg_q   <= tx_byte;
                        cur_rx_q  <= rd_dir_q && !addr_phase_q;
                        ack_drv_q <= ack_en;
                        if (addr_phase_q) rd_dir_q <= tx_byte[0];
                    end
                end
                E_START: begin
                    if (adv) begin
                        qtr_q <= qtr_q + 2'd1;
                        unique case (qtr_q)
                            2'd0: sda_low <= 1'b0;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b1;
                            default: begin
                                scl_low      <= 1'b1;
                                status       <= owned_q ? SC_RSTART : SC_START;
                                owned_q      <= 1'b1;
                                addr_phase_q <= 1'b1;
                                step_done    <= 1'b1;
                            end
                        endcase
                    end
                end
                E_BIT: begin
                    if (adv) begin
                        qtr_q <= qtr_q + 2'd1;
                        unique case (qtr_q)
                            2'd0: begin
                                if (bitn_q == ACK_SLOT) sda_low <= cur_rx_q && ack_drv_q;
                                else                    sda_low <= !cur_rx_q && !shreg_q[BYTE_W-1];
                            end
                            2'd1: scl_low <= 1'b0;
                            2'd2: begin
                                if (bitn_q == ACK_SLOT) ack_seen_q <= !sda_i;
                                else shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
                            end
                            default: begin
                                scl_low <= 1'b1;
                                if (bitn_q == ACK_SLOT) begin
                                    step_done <= 1'b1;
                                    if (cur_rx_q) begin
                                        rx_byte   <= shreg_q;
                                        data_load <= 1'b1;
                                        status    <= ack_drv_q ? SC_DR_ACK : SC_DR_NAK;
                                    end else if (addr_phase_q) begin
                                        addr_phase_q <= 1'b0;
                                        if (rd_dir_q) status <= ack_seen_q ? SC_AR_ACK : SC_AR_NAK;
                                        else          status <= ack_seen_q ? SC_AW_ACK : SC_AW_NAK;
                                    end else begin
                                        status <= ack_seen_q ? SC_DW_ACK : SC_DW_NAK;
                                    end
                                end else begin
                                    bitn_q <= bitn_q + BN_W'(1);
                                end
                            end
                        endcase
                    end
                end
                E_STOP: begin
                    if (adv) begin
                        qtr_q <= qtr_q + 2'd1;
                        unique case (qtr_q)
                            2'd0: sda_low <= 1'b1;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b0;
                            default: begin
                                status       <= SC_IDLE;
                                owned_q      <= 1'b0;
                                addr_phase_q <= 1'b0;
                                stop_done    <= 1'b1;
                            end
                        endcase
                    end
                end
                default: qtr_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_byte_ctrl.sv
module i2cm_byte_ctrl
    import i2cm_pkg::*;
#(
    parameter logic [7:0] BAUD_RST = 8'h44,
    parameter int         RA_W     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            irq,
    input  logic            scl_i,
    output logic            scl_oe,
    input  logic            sda_i,
    output logic            sda_oe
);
    logic       srst, rst;
    logic       wr_ctrl, launch;
    logic [7:0] data_q, baud_q, own_q;
    logic       ien_q, en_q, start_q, stop_q, flag_q, ackc_q;
    logic       tick, run, step_done, stop_done, data_load, eng_idle, eng_in_bit;
    logic [7:0] status, rx_byte;

    assign srst    = reg_wr && (reg_addr == RA_W'(RO_SRST));
    assign rst     = !rst_n || srst;
    assign wr_ctrl = reg_wr && (reg_addr == RA_W'(RO_CTRL));
    assign launch  = wr_ctrl && reg_wdata[CB_EN] && !reg_wdata[CB_FLAG];
    assign irq     = flag_q && ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            baud_q  <= BAUD_RST;
            own_q   <= '0;
            ien_q   <= 1'b0;
            en_q    <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            flag_q  <= 1'b0;
            ackc_q  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_W'(RO_DATA)) data_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_W'(RO_STAT)) baud_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_W'(RO_OWN))  own_q  <= reg_wdata;
            if (wr_ctrl) begin
                ien_q   <= reg_wdata[CB_IEN];
                en_q    <= reg_wdata[CB_EN];
                start_q <= reg_wdata[CB_START];
                stop_q  <= reg_wdata[CB_STOP];
                ackc_q  <= reg_wdata[CB_ACK];
                if (!reg_wdata[CB_FLAG]) flag_q <= 1'b0;
            end
            if (data_load) data_q <= rx_byte;
            if (step_done) begin
                flag_q  <= 1'b1;
                start_q <= 1'b0;
            end
            if (stop_done) stop_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_W'(RO_DATA): reg_rdata = data_q;
            RA_W'(RO_CTRL): reg_rdata = {ien_q, en_q, start_q, stop_q, flag_q, ackc_q, 2'b00};
            RA_W'(RO_STAT): reg_rdata = status;
            RA_W'(RO_OWN):  reg_rdata = own_q;
            default:        reg_rdata = 8'h00;
        endcase
    end

    i2cm_tick #(.M_W(4), .N_W(4)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .divider (baud_q),
        .tick    (tick)
    );

    i2cm_engine #(.BYTE_W(8)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .launch    (launch),
        .req_start (reg_wdata[CB_START]),
        .req_stop  (reg_wdata[CB_STOP]),
        .ack_en    (reg_wdata[CB_ACK]),
        .tx_byte   (data_q),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_low   (scl_oe),
        .sda_low   (sda_oe),
        .step_done (step_done),
        .stop_done (stop_done),
        .data_load (data_load),
        .status    (status),
        .rx_byte   (rx_byte),
        .run       (run),
        .idle      (eng_idle),
        .in_bit    (eng_in_bit)
    );
endmodule

// File: rtl/i2cm_byte_ctrl_chk.sv
module i2cm_byte_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flag,
    input logic       step_done,
    input logic       stop_done,
    input logic       data_load,
    input logic [7:0] status,
    input logic       eng_idle,
    input logic       eng_in_bit,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       wr_ctrl,
    input logic       wr_en_bit
);
    AST_FLAG_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(step_done)); // R8

    AST_STOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> !flag); // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |-> (!scl_oe && !sda_oe)); // R7

    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> scl_oe); // R8

    AST_RX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        data_load |-> (status == 8'h50 || status == 8'h58)); // R6

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_en_bit && eng_idle) |=> eng_idle); // R10

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_in_bit && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R13
endmodule

bind i2cm_byte_ctrl i2cm_byte_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag       (flag_q),
    .step_done  (step_done),
    .stop_done  (stop_done),
    .data_load  (data_load),
    .status     (status),
    .eng_idle   (eng_idle),
    .eng_in_bit (eng_in_bit),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .wr_ctrl    (wr_ctrl),
    .wr_en_bit  (reg_wdata[6])
);

// File: tb/i2cm_byte_ctrl_test.sv
module i2cm_byte_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       s_sda_low;
    logic       scl, sda;
    int         checks = 0;
    int         failures = 0;

    always #4 clk = ~clk;

    assign scl = ~scl_oe;
    assign sda = ~(sda_oe | s_sda_low);

    i2cm_byte_ctrl #(.BAUD_RST(8'h12)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl), .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe)
    );

    // ---------------- slave model ----------------
    logic       slave_ack = 1'b1;
    logic       scl_p, sda_p, s_rd, s_done;
    logic [3:0] sbit, sbyte;
    logic [7:0] sshr, s_last, stx;

    always_ff @(posedge clk) begin
        scl_p <= scl;
        sda_p <= sda;
        if (!rst_n) begin
            sbit <= 4'd15; sbyte <= 4'd0; s_rd <= 1'b0; s_done <= 1'b1;
            sshr <= 8'h00; s_last <= 8'h00;
        end else if (scl && scl_p && sda_p && !sda) begin
            sbit <= 4'd15; sbyte <= 4'd0; s_rd <= 1'b0; s_done <= 1'b0;
        end else begin
            if (scl && !scl_p) begin
                if (sbit < 4'd8) sshr <= {sshr[6:0], sda};
                if (sbit == 4'd7) s_last <= {sshr[6:0], sda};
                if (sbit == 4'd7 && sbyte == 4'd0) s_rd <= sda;
                if (sbit == 4'd8 && sbyte == 4'd0 && !slave_ack) s_done <= 1'b1;
                if (sbit == 4'd8 && sbyte != 4'd0 && s_rd && sda) s_done <= 1'b1;
            end
            if (!scl && scl_p) begin
                if (sbit == 4'd15)     sbit <= 4'd0;
                else if (sbit == 4'd8) begin sbit <= 4'd0; sbyte <= sbyte + 4'd1; end
                else                   sbit <= sbit + 4'd1;
            end
        end
    end

    always_comb begin
        stx = sbyte[0] ? 8'hC3 : 8'h5A;
        s_sda_low = 1'b0;
        if (!s_done) begin
            if (sbit == 4'd8 && (sbyte == 4'd0 || !s_rd)) s_sda_low = slave_ack;
            else if (sbit < 4'd8 && sbyte != 4'd0 && s_rd) s_sda_low = !((stx << sbit) >> 7);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_flag(output int cyc);
        logic [7:0] c;
        cyc = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd1, c);
            if (c[3]) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd2, s);
            if (s == 8'hF8) break;
            @(negedge clk);
        end
    endtask

    // op, byte, ack-select, slave-ack, status, data
    localparam logic [1:0] OP_ST = 2'd0, OP_TX = 2'd1, OP_RX = 2'd2, OP_SP = 2'd3;
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {OP_ST, 8'h00, 1'b0, 1'b1, 8'h08, 8'h00},
        {OP_TX, 8'hA0, 1'b0, 1'b1, 8'h18, 8'h00},
        {OP_TX, 8'h3C, 1'b0, 1'b1, 8'h28, 8'h00},
        {OP_TX, 8'h55, 1'b0, 1'b0, 8'h30, 8'h00},
        {OP_ST, 8'h00, 1'b0, 1'b1, 8'h10, 8'h00},
        {OP_TX, 8'hA1, 1'b0, 1'b1, 8'h40, 8'h00},
        {OP_RX, 8'h00, 1'b1, 1'b1, 8'h50, 8'hC3},
        {OP_RX, 8'h00, 1'b0, 1'b1, 8'h58, 8'h5A},
        {OP_SP, 8'h00, 1'b0, 1'b1, 8'hF8, 8'h00},
        {OP_ST, 8'h00, 1'b0, 1'b1, 8'h08, 8'h00},
        {OP_TX, 8'hA1, 1'b0, 1'b0, 8'h48, 8'h00},
        {OP_SP, 8'h00, 1'b0, 1'b1, 8'hF8, 8'h00},
        {OP_ST, 8'h00, 1'b0, 1'b1, 8'h08, 8'h00},
        {OP_TX, 8'hA0, 1'b0, 1'b0, 8'h20, 8'h00},
        {OP_SP, 8'h00, 1'b0, 1'b1, 8'hF8, 8'h00}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int         cyc, lat1, lat2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, v); chk(v == 8'hF8, "R1 status", v, 8'hF8);
        rd(3'd1, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
        rd(3'd3, v); chk(v == 8'h00, "R1 own", v, 8'h00);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(scl && sda, "R1 lines", {scl, sda}, 2'b11);

        wr(3'd2, 8'h00); // R12 fastest divider

        for (int k = 0; k < NV; k++) begin
            logic [1:0] op; logic [7:0] b, es, ed; logic ac;
            {op, b, ac, slave_ack, es, ed} = VEC[k];
            unique case (op)
                OP_ST: begin
                    wr(3'd1, 8'hE0);
                    wait_flag(cyc);
                    rd(3'd2, v); chk(v == es, "R3 start status", v, es);
                    chk(irq == 1'b1, "R9 irq on flag", irq, 1);
                end
                OP_TX: begin
                    wr(3'd0, b);
                    wr(3'd1, 8'hC0);
                    wait_flag(cyc);
                    rd(3'd2, v);
                    chk(v == es, (k == 1 || k == 5 || k > 9) ? "R4 addr status" : "R5 data status", v, es);
                    chk(s_last == b, "R5 bits on wire", s_last, b);
                end
                OP_RX: begin
                    wr(3'd1, {5'b11000, ac, 2'b00});
                    wait_flag(cyc);
                    rd(3'd2, v); chk(v == es, "R6 rx status", v, es);
                    rd(3'd0, v); chk(v == ed, "R6 rx data", v, ed);
                end
                default: begin
                    wr(3'd1, 8'hD0);
                    wait_idle();
                    repeat (3) @(negedge clk);
                    rd(3'd1, v); chk(v[3] == 1'b0, "R7 no flag", v, 0);
                    rd(3'd2, v); chk(v == 8'hF8, "R7 idle status", v, 8'hF8);
                    chk(scl && sda, "R7 lines released", {scl, sda}, 2'b11);
                end
            endcase
        end

        // R9 / R8 / R2: flag handshake and interrupt gating
        slave_ack = 1'b1;
        wr(3'd1, 8'h60);
        wait_flag(cyc);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        rd(3'd1, v); chk(v == 8'h48, "R2 ctrl readback", v, 8'h48);
        wr(3'd0, 8'hA0);
        wr(3'd1, 8'hC8);
        chk(irq == 1'b1, "R9 irq enabled", irq, 1);
        repeat (40) @(negedge clk);
        rd(3'd1, v); chk(v[3] == 1'b1, "R8 flag kept", v, 1);
        rd(3'd2, v); chk(v == 8'h08, "R8 no step", v, 8'h08);
        chk(scl == 1'b0, "R8 scl held", scl, 0);
        wr(3'd1, 8'hC0);
        rd(3'd1, v); chk(v[3] == 1'b0, "R8 flag cleared", v, 0);
        wait_flag(cyc);
        rd(3'd2, v); chk(v == 8'h18, "R8 launched", v, 8'h18);
        wr(3'd1, 8'hD0);
        wait_idle();
        repeat (3) @(negedge clk);

        // R10 disabled engine ignores start
        wr(3'd1, 8'h20);
        repeat (40) @(negedge clk);
        rd(3'd2, v); chk(v == 8'hF8, "R10 status", v, 8'hF8);
        chk(scl && sda, "R10 lines", {scl, sda}, 2'b11);
        rd(3'd1, v); chk(v[3] == 1'b0, "R10 no flag", v, 0);

        // R12 / R11 shared offset, divider, soft reset
        wr(3'd3, 8'h5A);
        rd(3'd3, v); chk(v == 8'h5A, "R11 own stored", v, 8'h5A);
        rd(3'd2, v); chk(v == 8'hF8, "R12 read is status", v, 8'hF8);
        wr(3'd1, 8'hE0);
        wait_flag(lat1);
        chk(lat1 <= 12, "R12 fast divider", lat1, 12);
        wr(3'd1, 8'hD0);
        wait_idle();
        repeat (3) @(negedge clk);
        wr(3'd7, 8'h00);
        rd(3'd3, v); chk(v == 8'h00, "R11 own cleared", v, 8'h00);
        rd(3'd1, v); chk(v == 8'h00, "R11 ctrl cleared", v, 8'h00);
        rd(3'd2, v); chk(v == 8'hF8, "R11 status idle", v, 8'hF8);
        wr(3'd1, 8'hE0);
        wait_flag(lat2);
        chk(lat2 >= 28, "R11 divider reset", lat2, 28);
        wr(3'd1, 8'hD0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(scl && sda, "R7 final release", {scl, sda}, 2'b11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule